// File: doc/BRIEF.md
# Truth Table Capture and Equivalence Checker

This block keeps two one-output truth tables for a function of up to three inputs. The first table belongs to a reference circuit built from AND, OR and NOT gates. The second belongs to a circuit built only from NAND or only from NOR gates. A producer fills each table through its own load strobe, and only while that side reports its circuit as complete. The block drives per-row display data and a row-enable mask. It also compares the two stored tables and signals whether they agree.

A mode input selects whether the function has two or three inputs. The mode sets which rows are active, which rows are shown and which rows take part in the comparison. A side that holds no table is in a default state. In that state its displayed bits are zero and its default indicator is lit. Both sides return to this state when the mode changes. A side also returns to it when it stops reporting complete.

Top module: `tt_equiv_checker`

## Requirements
- R1: A synchronous active-high reset empties both tables. After reset both default indicators are high, the displayed bits are all zero, green and red are low, and the row-enable mask is 0x0F (two-input mode).
- R2: The row-enable mask follows the mode input one clock later: 0x0F for two-input mode (mode input 0) and 0xFF for three-input mode (mode input 1). Row k is bit k.
- R3: When a side's load strobe is high and that side is complete, the side stores the data one clock later. Bit k of the data is the output for input combination k. In two-input mode, rows 4 to 7 are stored as 0.
- R4: A load strobe has no effect on a side while that side is not complete.
- R5: A side whose complete input is low is in the default state after the next clock edge.
- R6: A cycle in which the mode input differs from the currently applied mode puts both sides into the default state, and any load in that cycle is ignored.
- R7: Green is high only while both sides hold tables that agree on every active row. Red is high only while both sides hold tables that differ on an active row. While either side is in default, both are low. If both tables are all ones, or both all zeros, the result is green. If only the NAND/NOR table is all ones and the reference is all zeros, the result is red.
- R8: In two-input mode, differences in rows 4 to 7 of the loaded data do not affect the comparison.
- R9: A side's default indicator is high exactly when that side holds no table, and its displayed bits are then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode3_i | input | 1 | 1 selects three-input mode, 0 selects two-input mode |
| ref_done_i | input | 1 | Reference side has every required slot filled |
| ref_load_i | input | 1 | Load strobe for the reference table |
| ref_tt_i | input | 8 | Reference truth table, bit k is row k |
| nn_done_i | input | 1 | NAND/NOR side has every required slot filled |
| nn_load_i | input | 1 | Load strobe for the NAND/NOR table |
| nn_tt_i | input | 8 | NAND/NOR truth table, bit k is row k |
| row_en_o | output | 8 | Active-row display enables |
| ref_bits_o | output | 8 | Stored reference table |
| nn_bits_o | output | 8 | Stored NAND/NOR table |
| ref_dflt_o | output | 1 | Reference side is in the default state |
| nn_dflt_o | output | 1 | NAND/NOR side is in the default state |
| green_o | output | 1 | Both tables are loaded and agree |
| red_o | output | 1 | Both tables are loaded and differ |

## Verification
Every piece of internal state reaches the ports within one clock. A wrong stored row appears in the displayed bits. It also appears in the green and red outputs on the first cycle in which both sides are valid. A stale valid flag shows up as a default indicator that does not match the displayed bits. A lagging mode register shows up as a row-enable mask that does not change on the cycle after the mode input changes. The bench compares all outputs against its model after every edge, so any such error is caught in the cycle it appears.

// File: rtl/tt_equiv_pkg.sv
package tt_equiv_pkg;

    typedef enum logic {
        MODE_IN2 = 1'b0,
        MODE_IN3 = 1'b1
    } tt_mode_e;

    localparam int SIDE_REF = 0;
    localparam int SIDE_NN  = 1;
    localparam int N_SIDES  = 2;

endpackage

// File: rtl/tt_side_store.sv
module tt_side_store #(
    parameter int ROWS = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            flush_i,
    input  logic            done_i,
    input  logic            load_i,
    input  logic [ROWS-1:0] data_i,
    input  logic [ROWS-1:0] mask_i,
    output logic [ROWS-1:0] tbl_o,
    output logic            vld_o
);

    typedef struct packed {
        logic [ROWS-1:0] tbl;
        logic            vld;
    } side_t;

    side_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i || !done_i) begin
            st_d = '0;
        end else if (load_i) begin
            st_d.tbl = data_i & mask_i;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_o = st_q.tbl;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/tt_masked_cmp.sv
module tt_masked_cmp #(
    parameter int ROWS = 8
) (
    input  logic [ROWS-1:0] a_i,
    input  logic [ROWS-1:0] b_i,
    input  logic [ROWS-1:0] mask_i,
    output logic            eq_o
);

    logic [ROWS-1:0] diff;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign diff[r] = (a_i[r] ^ b_i[r]) & mask_i[r];
    end

    assign eq_o = ~|diff;

endmodule

// File: rtl/tt_equiv_checker.sv
module tt_equiv_checker
    import tt_equiv_pkg::*;
#(
    parameter int IN_MAX = 3,
    localparam int ROWS = 1 << IN_MAX
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            mode3_i,
    input  logic            ref_done_i,
    input  logic            ref_load_i,
    input  logic [ROWS-1:0] ref_tt_i,
    input  logic            nn_done_i,
    input  logic            nn_load_i,
    input  logic [ROWS-1:0] nn_tt_i,
    output logic [ROWS-1:0] row_en_o,
    output logic [ROWS-1:0] ref_bits_o,
    output logic [ROWS-1:0] nn_bits_o,
    output logic            ref_dflt_o,
    output logic            nn_dflt_o,
    output logic            green_o,
    output logic            red_o
);

    localparam int SMALL_ROWS = 1 << (IN_MAX - 1);

    typedef struct packed {
        tt_mode_e mode;
    } top_t;

    top_t top_d, top_q;
    logic mode_chg;

    always_comb begin
        top_d      = top_q;
        mode_chg   = (tt_mode_e'(mode3_i) != top_q.mode);
        top_d.mode = tt_mode_e'(mode3_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            top_q.mode <= MODE_IN2;
        end else begin
            top_q <= top_d;
        end
    end

    logic [ROWS-1:0] mask;
    for (genvar r = 0; r < ROWS; r++) begin : g_mask
        if (r < SMALL_ROWS) begin : g_lo
            assign mask[r] = 1'b1;
        end else begin : g_hi
            assign mask[r] = (top_q.mode == MODE_IN3);
        end
    end

    logic            done_v [N_SIDES];
    logic            load_v [N_SIDES];
    logic [ROWS-1:0] data_v [N_SIDES];
    logic [ROWS-1:0] tbl_v  [N_SIDES];
    logic            vld_v  [N_SIDES];

    assign done_v[SIDE_REF] = ref_done_i;
    assign load_v[SIDE_REF] = ref_load_i;
    assign data_v[SIDE_REF] = ref_tt_i;
    assign done_v[SIDE_NN]  = nn_done_i;
    assign load_v[SIDE_NN]  = nn_load_i;
    assign data_v[SIDE_NN]  = nn_tt_i;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        tt_side_store #(.ROWS(ROWS)) u_store (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .flush_i (mode_chg),
            .done_i  (done_v[s]),
            .load_i  (load_v[s]),
            .data_i  (data_v[s]),
            .mask_i  (mask),
            .tbl_o   (tbl_v[s]),
            .vld_o   (vld_v[s])
        );
    end

    logic tables_eq;
    tt_masked_cmp #(.ROWS(ROWS)) u_cmp (
        .a_i    (tbl_v[SIDE_REF]),
        .b_i    (tbl_v[SIDE_NN]),
        .mask_i (mask),
        .eq_o   (tables_eq)
    );

    logic both_vld;
    assign both_vld   = vld_v[SIDE_REF] && vld_v[SIDE_NN];
    assign row_en_o   = mask;
    assign ref_bits_o = tbl_v[SIDE_REF];
    assign nn_bits_o  = tbl_v[SIDE_NN];
    assign ref_dflt_o = !vld_v[SIDE_REF];
    assign nn_dflt_o  = !vld_v[SIDE_NN];
    assign green_o    = both_vld && tables_eq;
    assign red_o      = both_vld && !tables_eq;

endmodule

// File: rtl/tt_equiv_checker_sva.sv
module tt_equiv_checker_sva #(
    parameter int IN_MAX = 3,
    localparam int ROWS = 1 << IN_MAX,
    localparam int SMALL_ROWS = 1 << (IN_MAX - 1)
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            mode3_i,
    input logic            ref_done_i,
    input logic            ref_load_i,
    input logic            nn_done_i,
    input logic [ROWS-1:0] row_en_o,
    input logic [ROWS-1:0] ref_bits_o,
    input logic [ROWS-1:0] nn_bits_o,
    input logic            ref_dflt_o,
    input logic            nn_dflt_o,
    input logic            green_o,
    input logic            red_o
);

    // R7
    green_red_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(green_o && red_o));

    // R7
    verdict_needs_both_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (green_o || red_o) == (!ref_dflt_o && !nn_dflt_o));

    // R9
    ref_dflt_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ref_dflt_o |-> (ref_bits_o == '0));

    // R9
    nn_dflt_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        nn_dflt_o |-> (nn_bits_o == '0));

    // R6
    mode_flush_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode3_i != row_en_o[ROWS-1]) |=> (ref_dflt_o && nn_dflt_o));

    // R5
    ref_incomplete_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !ref_done_i |=> ref_dflt_o);

    // R5
    nn_incomplete_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !nn_done_i |=> nn_dflt_o);

    // R3
    ref_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_load_i && ref_done_i && (mode3_i == row_en_o[ROWS-1])) |=> !ref_dflt_o);

    // R2
    row_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode3_i == row_en_o[ROWS-1]) |=> (row_en_o[ROWS-1] == $past(mode3_i)));

    // R2
    low_rows_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        row_en_o[SMALL_ROWS-1:0] == '1);

endmodule

bind tt_equiv_checker tt_equiv_checker_sva #(.IN_MAX(IN_MAX)) u_sva (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .mode3_i    (mode3_i),
    .ref_done_i (ref_done_i),
    .ref_load_i (ref_load_i),
    .nn_done_i  (nn_done_i),
    .row_en_o   (row_en_o),
    .ref_bits_o (ref_bits_o),
    .nn_bits_o  (nn_bits_o),
    .ref_dflt_o (ref_dflt_o),
    .nn_dflt_o  (nn_dflt_o),
    .green_o    (green_o),
    .red_o      (red_o)
);

// File: tb/tb_tt_equiv_checker.sv
module tb_tt_equiv_checker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode3 = 1'b0;
    logic       ref_done = 1'b0, ref_load = 1'b0;
    logic [7:0] ref_tt = '0;
    logic       nn_done = 1'b0, nn_load = 1'b0;
    logic [7:0] nn_tt = '0;
    logic [7:0] row_en, ref_bits, nn_bits;
    logic       ref_dflt, nn_dflt, green, red;

    always #4 clk = ~clk;

    tt_equiv_checker dut (
        .clk_i(clk), .rst_i(rst), .mode3_i(mode3),
        .ref_done_i(ref_done), .ref_load_i(ref_load), .ref_tt_i(ref_tt),
        .nn_done_i(nn_done), .nn_load_i(nn_load), .nn_tt_i(nn_tt),
        .row_en_o(row_en), .ref_bits_o(ref_bits), .nn_bits_o(nn_bits),
        .ref_dflt_o(ref_dflt), .nn_dflt_o(nn_dflt),
        .green_o(green), .red_o(red)
    );

    int         n_cmp = 0, n_bad = 0, n_cyc = 0;
    bit         started = 0;
    string      phase = "R1";
    int         m_mode = 0;
    int         m_ref = 0, m_nn = 0;
    bit         m_rv = 0, m_nv = 0;

    function automatic int msk(int md);
        return (md != 0) ? 8'hFF : 8'h0F;
    endfunction

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        started <= 1;
        n_cyc   <= n_cyc + 1;
        if (rst) begin
            m_mode = 0; m_ref = 0; m_nn = 0; m_rv = 0; m_nv = 0;
        end else if (int'(mode3) != m_mode) begin
            m_mode = int'(mode3); m_ref = 0; m_nn = 0; m_rv = 0; m_nv = 0;
        end else begin
            if (!ref_done) begin m_ref = 0; m_rv = 0; end
            else if (ref_load) begin m_ref = int'(ref_tt) & msk(m_mode); m_rv = 1; end
            if (!nn_done) begin m_nn = 0; m_nv = 0; end
            else if (nn_load) begin m_nn = int'(nn_tt) & msk(m_mode); m_nv = 1; end
        end
    end

    task automatic cmp1(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", phase, what, act, exp, n_cyc);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            bit both;
            bit eq;
            both = m_rv && m_nv;
            eq   = (((m_ref ^ m_nn) & msk(m_mode)) == 0);
            cmp1("R2 row_en", int'(row_en), msk(m_mode));
            cmp1("R3 ref_bits", int'(ref_bits), m_ref);
            cmp1("R3 nn_bits", int'(nn_bits), m_nn);
            cmp1("R9 ref_dflt", int'(ref_dflt), int'(!m_rv));
            cmp1("R9 nn_dflt", int'(nn_dflt), int'(!m_nv));
            cmp1("R7 green", int'(green), int'(both && eq));
            cmp1("R7 red", int'(red), int'(both && !eq));
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(bit side_nn, logic [7:0] v);
        if (side_nn) begin nn_tt = v; nn_load = 1; end
        else begin ref_tt = v; ref_load = 1; end
        step(1);
        ref_load = 0; nn_load = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        phase = "R3";
        ref_done = 1; nn_done = 1;
        step(1);
        load(0, 8'hA6);
        step(1);
        phase = "R8";
        load(1, 8'h56);
        step(1);
        phase = "R7";
        load(1, 8'h05);
        step(1);
        phase = "R4";
        ref_done = 0;
        load(0, 8'h0F);
        step(1);
        phase = "R5";
        ref_done = 1;
        step(1);
        load(0, 8'h05);
        step(1);
        nn_done = 0;
        step(2);
        nn_done = 1;
        load(1, 8'h05);
        step(1);
        phase = "R6";
        mode3 = 1;
        load(0, 8'hFF);
        step(2);
        phase = "R7";
        load(0, 8'hFF);
        load(1, 8'hFF);
        step(1);
        load(0, 8'h00);
        load(1, 8'h00);
        step(1);
        load(1, 8'hFF);
        step(1);
        load(0, 8'h96);
        load(1, 8'h96);
        step(1);
        load(1, 8'h16);
        step(1);
        phase = "R6";
        mode3 = 0;
        step(2);
        phase = "R2";
        mode3 = 1;
        step(1);
        mode3 = 0;
        step(2);
        phase = "R1";
        load(0, 8'h03);
        load(1, 8'h03);
        rst = 1;
        step(2);
        rst = 0;
        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule